// File: doc/BRIEF.md
# Microprogram Sequencer with Subroutine Stack

This block computes, every clock, the address of the next microinstruction for a microprogrammed controller. The executing microword supplies an instruction code, a branch target, a condition-select field and a polarity bit, and a bank of external status lines is available for testing. The sequencer chooses among the incremented address, the branch target and a saved return address. It drives that choice combinationally on its address output, so a control store and its pipeline register can latch it at the next edge.

A microprogram counter always holds the last issued address plus one. Subroutine calls save this value on a small last-in first-out stack. Returns take the newest saved value as the next address in the same cycle. The stack pointer itself is lowered one cycle later. Calls and returns can be unconditional or can depend on the tested condition, so nested microroutines run without hard-coded return targets.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `next_addr` is 0, the stack is emptied (`empty`=1, `full`=0) and `err` is cleared. The first instruction after reset therefore sees a microprogram counter of 1.
- R2: Op code 0 (continue) outputs the microprogram counter on `next_addr`. At every non-reset edge the counter loads `next_addr`+1, modulo 2^8.
- R3: Op code 1 (jump) outputs `br_addr` on `next_addr`.
- R4: The tested condition is `cond_in[cond_sel]` XOR `polarity`. Op code 2 (conditional jump) outputs `br_addr` when this is 1 and the microprogram counter otherwise.
- R5: Op code 3 (call), and op code 4 (conditional call) with a true condition, output `br_addr` and push the microprogram counter onto the stack.
- R6: Op code 5 (return), and op code 6 (conditional return) with a true condition, output the newest stack entry on `next_addr` in that same cycle and pop it.
- R7: A conditional call or return whose condition is false behaves as continue: `next_addr` is the microprogram counter and the stack is not changed.
- R8: Returns yield saved addresses in the reverse order of their calls, including back-to-back returns, for up to 4 nested levels.
- R9: The stack pointer changes by one per push or pop. A push updates `full`/`empty` at the next edge. A pop lowers the pointer, and updates `full`/`empty`, only at the second edge after the return.
- R10: A push with 4 entries held is dropped, but the call still jumps to `br_addr`. A pop with no entries is dropped and the instruction continues to the microprogram counter. Either event sets `err`, which stays high until reset. Op code 7 behaves as continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Instruction code of the executing microword |
| br_addr | input | 8 | Branch / call target address |
| cond_sel | input | 3 | Selects one of the condition inputs |
| polarity | input | 1 | Inverts the selected condition when 1 |
| cond_in | input | 8 | External condition inputs |
| next_addr | output | 8 | Next microinstruction address |
| full | output | 1 | Stack pointer at maximum depth |
| empty | output | 1 | Stack pointer at zero |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
A small control store runs a microprogram with a chain of four nested calls. The chain unwinds through back-to-back returns, which shows whether the read side correctly follows the delayed pointer. Random condition inputs steer the conditional jump, call and return entries down both outcomes with both polarities, which separates a taken branch from a continue and confirms that the stack stays untouched on a false condition. A call issued at full depth and a return issued on an empty stack exercise the dropped push and pop and the sticky error. A reset in mid-run shows that the whole state clears.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 4;
    localparam int NCOND  = 8;
    localparam int SEL_W  = $clog2(NCOND);

    typedef enum logic [2:0] {
        OP_CONT  = 3'd0,
        OP_JMP   = 3'd1,
        OP_JCND  = 3'd2,
        OP_CALL  = 3'd3,
        OP_CCALL = 3'd4,
        OP_RET   = 3'd5,
        OP_CRET  = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    function automatic logic op_is_call(op_e o);
        return (o == OP_CALL) || (o == OP_CCALL);
    endfunction

    function automatic logic op_is_ret(op_e o);
        return (o == OP_RET) || (o == OP_CRET);
    endfunction

    function automatic logic op_needs_cond(op_e o);
        return (o == OP_JCND) || (o == OP_CCALL) || (o == OP_CRET);
    endfunction

endpackage

// File: rtl/useq_cond.sv
module useq_cond #(
    parameter int NCOND = useq_pkg::NCOND,
    parameter int SEL_W = useq_pkg::SEL_W
) (
    input  logic [NCOND-1:0] cond_in,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic             polarity,
    output logic             cond_ok
);
    always_comb begin
        cond_ok = cond_in[cond_sel] ^ polarity;
    end
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
#(
    parameter int ADDR_W = useq_pkg::ADDR_W
) (
    input  op_e               op,
    input  logic              cond_ok,
    input  logic [ADDR_W-1:0] upc,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [ADDR_W-1:0] tos_data,
    input  logic              can_push,
    input  logic              can_pop,
    output logic [ADDR_W-1:0] nxt,
    output logic              push,
    output logic              pop,
    output logic              bad
);
    logic taken;

    always_comb begin
        taken = !op_needs_cond(op) || cond_ok;
        nxt   = upc;
        push  = 1'b0;
        pop   = 1'b0;
        bad   = 1'b0;
        case (op)
            OP_JMP:  nxt = br_addr;
            OP_JCND: if (cond_ok) nxt = br_addr;
            OP_CALL, OP_CCALL: begin
                if (taken) begin
                    nxt = br_addr;
                    if (can_push) push = 1'b1;
                    else          bad  = 1'b1;
                end
            end
            OP_RET, OP_CRET: begin
                if (taken) begin
                    if (can_pop) begin
                        nxt = tos_data;
                        pop = 1'b1;
                    end else begin
                        bad = 1'b1;
                    end
                end
            end
            default: nxt = upc;
        endcase
    end
endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
    parameter int ADDR_W = useq_pkg::ADDR_W,
    parameter int DEPTH  = useq_pkg::DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              bad,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] tos_data,
    output logic              can_push,
    output logic              can_pop,
    output logic              full,
    output logic              empty,
    output logic              err
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PW-1:0]     cnt_q;
    logic              pend_q;
    logic              err_q;
    logic [PW-1:0]     eff;
    logic [PW-1:0]     top_idx;

    // Effective depth: a pop issued last cycle is already accounted for here
    always_comb begin
        eff      = cnt_q - PW'(pend_q);
        top_idx  = eff - PW'(1);
        can_push = (eff != DEPTH_P);
        can_pop  = (eff != '0);
        tos_data = mem[top_idx[IW-1:0]];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst && push && (eff == PW'(i))) mem[i] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_q - PW'(pend_q) + PW'(push);
            pend_q <= pop;
            err_q  <= err_q | bad;
        end
    end

    assign full  = (cnt_q == DEPTH_P);
    assign empty = (cnt_q == '0);
    assign err   = err_q;

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= DEPTH_P);

    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + PW'(1)) ||
        (cnt_q == $past(cnt_q) - PW'(1)));

    assert_pop_lag_R9: assert property (@(posedge clk) disable iff (rst)
        (pop && !pend_q) |=> (cnt_q == $past(cnt_q)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    assert_no_push_full_R10: assert property (@(posedge clk) disable iff (rst)
        !(push && (eff == DEPTH_P)));
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int ADDR_W = useq_pkg::ADDR_W,
    parameter int DEPTH  = useq_pkg::DEPTH,
    parameter int NCOND  = useq_pkg::NCOND,
    parameter int SEL_W  = $clog2(NCOND)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic              polarity,
    input  logic [NCOND-1:0]  cond_in,
    output logic [ADDR_W-1:0] next_addr,
    output logic              full,
    output logic              empty,
    output logic              err
);
    op_e               op_q;
    logic              cond_ok;
    logic [ADDR_W-1:0] upc_q;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] tos_data;
    logic              push, pop, bad;
    logic              can_push, can_pop;

    assign op_q = op_e'(op);

    useq_cond #(.NCOND(NCOND), .SEL_W(SEL_W)) u_cond (
        .cond_in (cond_in),
        .cond_sel(cond_sel),
        .polarity(polarity),
        .cond_ok (cond_ok)
    );

    useq_nextaddr #(.ADDR_W(ADDR_W)) u_next (
        .op      (op_q),
        .cond_ok (cond_ok),
        .upc     (upc_q),
        .br_addr (br_addr),
        .tos_data(tos_data),
        .can_push(can_push),
        .can_pop (can_pop),
        .nxt     (nxt),
        .push    (push),
        .pop     (pop),
        .bad     (bad)
    );

    useq_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .pop     (pop),
        .bad     (bad),
        .din     (upc_q),
        .tos_data(tos_data),
        .can_push(can_push),
        .can_pop (can_pop),
        .full    (full),
        .empty   (empty),
        .err     (err)
    );

    assign next_addr = rst ? '0 : nxt;

    always_ff @(posedge clk) begin
        upc_q <= next_addr + ADDR_W'(1);
    end

    assert_upc_follow_R2: assert property (@(posedge clk) disable iff (rst)
        upc_q == ADDR_W'($past(next_addr) + ADDR_W'(1)));

    assert_jump_target_R3: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_JMP) |-> (next_addr == br_addr));

    assert_call_target_R5: assert property (@(posedge clk) disable iff (rst)
        push |-> (next_addr == br_addr));

    assert_fail_cont_R7: assert property (@(posedge clk) disable iff (rst)
        (op_needs_cond(op_q) && !cond_ok) |-> (next_addr == upc_q && !push && !pop));
endmodule

// File: tb/useq_top_tb_top.sv
module useq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op = 3'd0;
    logic [7:0] br_addr = 8'd0;
    logic [2:0] cond_sel = 3'd0;
    logic       polarity = 1'b0;
    logic [7:0] cond_in = 8'd0;
    logic [7:0] next_addr;
    logic       full, empty, err;

    always #2 clk = ~clk;

    useq_top dut_i (
        .clk(clk), .rst(rst), .op(op), .br_addr(br_addr), .cond_sel(cond_sel),
        .polarity(polarity), .cond_in(cond_in), .next_addr(next_addr),
        .full(full), .empty(empty), .err(err)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [2:0] p_op [256];
    logic [7:0] p_br [256];
    logic [2:0] p_sel[256];
    logic       p_pol[256];

    int q[$];
    int m_upc, m_cnt, m_pend;
    bit m_err;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic put(int a, int o, int b, int s, int p);
        p_op[a] = 3'(o); p_br[a] = 8'(b); p_sel[a] = 3'(s); p_pol[a] = p[0];
    endtask

    task automatic do_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            op = 3'd0;
            #1;
            if (i > 0) begin
                chk("R1 addr", next_addr, 0);
                chk("R1 empty", empty, 1);
                chk("R1 full", full, 0);
                chk("R1 err", err, 0);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        m_upc = 1; m_cnt = 0; m_pend = 0; m_err = 0;
    endtask

    // One microinstruction: drive, compare against the model, advance the model
    task automatic step(input int a, output int nxt);
        int  exp;
        bit  condv, taken, pushed, popped, badv;
        string tag;
        op = p_op[a]; br_addr = p_br[a]; cond_sel = p_sel[a]; polarity = p_pol[a];
        cond_in = 8'($urandom);
        #1;
        condv  = cond_in[p_sel[a]] ^ p_pol[a];
        exp    = m_upc;
        pushed = 0; popped = 0; badv = 0;
        tag    = "R2";
        case (p_op[a])
            3'd1: begin exp = p_br[a]; tag = "R3"; end
            3'd2: begin if (condv) exp = p_br[a]; tag = "R4"; end
            3'd3, 3'd4: begin
                taken = (p_op[a] == 3'd3) || condv;
                tag = taken ? "R5" : "R7";
                if (taken) begin
                    exp = p_br[a];
                    if (q.size() < 4) begin q.push_front(m_upc); pushed = 1; end
                    else begin badv = 1; tag = "R10"; end
                end
            end
            3'd5, 3'd6: begin
                taken = (p_op[a] == 3'd5) || condv;
                tag = taken ? "R6/R8" : "R7";
                if (taken) begin
                    if (q.size() > 0) begin exp = q.pop_front(); popped = 1; end
                    else begin badv = 1; tag = "R10"; end
                end
            end
            default: tag = "R2";
        endcase
        chk(tag, next_addr, exp);
        chk("R9 full", full, m_cnt == 4);
        chk("R9 empty", empty, m_cnt == 0);
        chk("R10 err", err, m_err);
        @(posedge clk);
        m_err  = m_err | badv;
        m_cnt  = m_cnt - m_pend + pushed;
        m_pend = popped;
        m_upc  = (exp + 1) & 255;
        nxt    = exp;
        @(negedge clk);
    endtask

    task automatic run(int n);
        int cur = 0;
        for (int i = 0; i < n; i++) step(cur, cur);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) put(a, 0, 0, 0, 0);
        put(0, 0, 0, 0, 0);
        put(1, 1, 8, 0, 0);
        put(8, 3, 16, 0, 0);
        put(9, 2, 40, 2, 0);
        put(10, 4, 16, 3, 1);
        put(11, 1, 64, 0, 0);
        put(16, 3, 24, 0, 0);
        put(17, 6, 0, 1, 0);
        put(18, 5, 0, 0, 0);
        put(24, 3, 32, 0, 0);
        put(25, 5, 0, 0, 0);
        put(32, 3, 48, 0, 0);
        put(33, 5, 0, 0, 0);
        put(48, 4, 56, 0, 0);
        put(49, 5, 0, 0, 0);
        put(56, 1, 49, 0, 0);
        put(40, 3, 16, 0, 0);
        put(41, 1, 11, 0, 0);
        put(64, 5, 0, 0, 0);
        put(65, 7, 0, 0, 0);
        put(66, 1, 0, 0, 0);

        do_reset();
        run(400);
        do_reset();
        run(400);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule